// File: doc/BRIEF.md
# Half-Cycle RMS Swell Detector

This block watches three signed voltage sample streams (phases A, B and C) and decides once per half-cycle whether each phase is in a swell. One of the phases is chosen as the dominant phase. A debounced sign-change detector on that phase marks the half-cycle edges. Between two edges the block sums the squares of every phase's raw samples and counts the samples. At each edge it judges each phase's mean square against the square of that phase's own threshold. This gives the same answer as an RMS-versus-threshold test, with no square root and no divider.

A small register port holds three 32-bit thresholds, one per phase, and the dominant-phase select. A sample is a 24-bit two's-complement fraction of full scale (value = code / 2^23). A threshold is an unsigned fraction of full scale (value = code / 2^32). The detector works on the native per-phase voltages. The mean square covers the whole sampled waveform, fundamental and harmonics together. A window stops taking samples once it holds 1024 of them.

Top module: `swell_monitor`

## Requirements
- R1: After reset, `swell_flags` is 0, `decision_valid` is 0, and all four registers read back as 0.
- R2: Register addresses: 0, 1 and 2 hold the 32-bit thresholds of phases A, B and C. Address 3 holds the dominant select in bits [1:0], and its other bits read 0. `reg_rd_data` shows the register at `reg_addr` one cycle after the address is applied.
- R3: A half-cycle edge is a change of the dominant sample's sign bit (bit 23) that holds for 2 consecutive valid samples. A single sample of the opposite sign followed by one of the old sign causes no edge.
- R4: At an edge, `decision_valid` is high for exactly one cycle. That cycle follows the clock edge that captures the confirming sample. The first edge after reset, or after a restart, only opens a window and gives no decision.
- R5: At a decision, flag x (bit 0 = A, bit 1 = B, bit 2 = C) is 1 exactly when sum(s^2) * 2^18 > count * T^2. Here s are the raw codes of all samples in the window and T is the threshold code. This means the window RMS is strictly above the threshold, so equality gives 0.
- R6: Each phase is judged only against its own threshold and its own samples.
- R7: `swell_flags` holds its value in every cycle without a decision.
- R8: A threshold write takes effect at the next edge. The window that is open when the write happens is still judged against the threshold that was in force when that window opened.
- R9: Dominant select: 0 chooses A, 1 chooses B, 2 chooses C, and 3 chooses A. A write that changes its value restarts the detector: the window contents are dropped, the sign tracker returns to positive, and the next edge only opens a window.
- R10: The sample that confirms an edge is the first sample of the new window. Earlier samples, including the pending opposite-sign sample, belong to the window that closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new sample set is present on the three sample inputs |
| smp_a | input | 24 | Phase A sample, signed fraction |
| smp_b | input | 24 | Phase B sample, signed fraction |
| smp_c | input | 24 | Phase C sample, signed fraction |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Registered read data |
| swell_flags | output | 3 | Per-phase swell flags, bit 0 = A |
| decision_valid | output | 1 | One-cycle strobe when the flags carry a new decision |

## Verification
The confirming sample of an edge is captured on one rising edge, and the strobe and the new flags are registered on that same edge. Read data likewise appears one cycle after the address. The bench applies every input at a falling edge and reads the outputs at the next falling edge, which is one register stage later. A threshold write shows its effect only at the decision after the next edge. The bench therefore checks the decision that closes the window in which the write happened, and then the decision after it. A reference model built from the requirements predicts the strobe and the flags for every sample, so the timing is checked on every sample and not only at the decisions.

// File: rtl/swell_pkg.sv
package swell_pkg;
  localparam int NUM_PH = 3;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_DOM = 2'd3;

  typedef enum logic [1:0] {
    DOM_A   = 2'd0,
    DOM_B   = 2'd1,
    DOM_C   = 2'd2,
    DOM_A_2 = 2'd3
  } dom_sel_e;
endpackage

// File: rtl/swell_zc.sv
module swell_zc #(
  parameter int SAMPLE_W = 24,
  parameter int DEBOUNCE = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] dom_smp,
  output logic                boundary
);
  localparam int RUN_W = $clog2(DEBOUNCE + 1);

  logic             pol_q;
  logic [RUN_W-1:0] run_q;
  logic             opp;

  assign opp      = dom_smp[SAMPLE_W-1] != pol_q;
  assign boundary = smp_valid && !restart && opp && (run_q == RUN_W'(DEBOUNCE - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pol_q <= 1'b0;
      run_q <= '0;
    end else if (smp_valid) begin
      if (boundary) begin
        pol_q <= ~pol_q;
        run_q <= '0;
      end else if (opp) begin
        run_q <= run_q + 1'b1;
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/swell_phase.sv
module swell_phase #(
  parameter int SAMPLE_W    = 24,
  parameter int THR_W       = 32,
  parameter int MAX_SAMPLES = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp,
  input  logic                boundary,
  input  logic [THR_W-1:0]    thr,
  output logic                over,
  output logic                nonempty
);
  localparam int CNT_W = $clog2(MAX_SAMPLES + 1);
  localparam int SQ_W  = 2 * SAMPLE_W - 1;
  localparam int ACC_W = SQ_W + CNT_W;
  localparam int SHIFT = 2 * THR_W - 2 * (SAMPLE_W - 1);
  localparam int CMP_W = 2 * THR_W + CNT_W + 1;

  logic signed [2*SAMPLE_W-1:0] prod;
  logic [SQ_W-1:0]              sq;
  logic [ACC_W-1:0]             acc_q;
  logic [CNT_W-1:0]             cnt_q;
  logic [CMP_W-1:0]             lhs, rhs;

  assign prod = $signed(smp) * $signed(smp);
  assign sq   = prod[SQ_W-1:0];

  // mean square vs threshold squared, both sides brought to weight 2^-64
  assign lhs      = CMP_W'({acc_q, {SHIFT{1'b0}}});
  assign rhs      = CMP_W'(thr) * CMP_W'(thr) * CMP_W'(cnt_q);
  assign nonempty = cnt_q != '0;
  assign over     = nonempty && (lhs > rhs);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (smp_valid) begin
      if (boundary) begin
        acc_q <= ACC_W'(sq);
        cnt_q <= CNT_W'(1);
      end else if (cnt_q != CNT_W'(MAX_SAMPLES)) begin
        acc_q <= acc_q + ACC_W'(sq);
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/swell_regs.sv
module swell_regs
  import swell_pkg::*;
#(
  parameter int THR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [REG_AW-1:0]             addr,
  input  logic [THR_W-1:0]              wr_data,
  output logic [NUM_PH-1:0][THR_W-1:0]  thr_live,
  output dom_sel_e                      dom_sel,
  output logic                          dom_change,
  output logic [THR_W-1:0]              rd_data
);
  logic [THR_W-1:0] thr_q [NUM_PH];
  dom_sel_e         dom_q;

  assign dom_change = wr_en && (addr == ADDR_DOM) && (wr_data[1:0] != dom_q);
  assign dom_sel    = dom_q;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_out
    assign thr_live[p] = thr_q[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PH; p++) thr_q[p] <= '0;
      dom_q   <= DOM_A;
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        if (addr == ADDR_DOM) dom_q <= dom_sel_e'(wr_data[1:0]);
        else thr_q[addr] <= wr_data;
      end
      if (addr == ADDR_DOM) rd_data <= THR_W'(dom_q);
      else rd_data <= thr_q[addr];
    end
  end
endmodule

// File: rtl/swell_monitor.sv
module swell_monitor
  import swell_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int THR_W       = 32,
  parameter int MAX_SAMPLES = 1024,
  parameter int DEBOUNCE    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_a,
  input  logic [SAMPLE_W-1:0] smp_b,
  input  logic [SAMPLE_W-1:0] smp_c,
  input  logic                reg_wr_en,
  input  logic [1:0]          reg_addr,
  input  logic [THR_W-1:0]    reg_wr_data,
  output logic [THR_W-1:0]    reg_rd_data,
  output logic [2:0]          swell_flags,
  output logic                decision_valid
);
  logic [NUM_PH-1:0][THR_W-1:0]    thr_live;
  logic [NUM_PH-1:0][THR_W-1:0]    thr_act_q;
  logic [NUM_PH-1:0][SAMPLE_W-1:0] smp_vec;
  logic [NUM_PH-1:0]               over, nonempty;
  logic [SAMPLE_W-1:0]             dom_smp;
  dom_sel_e                        dom_sel;
  logic                            restart, boundary, armed_q;

  assign smp_vec = {smp_c, smp_b, smp_a};

  swell_regs #(.THR_W(THR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wr_data(reg_wr_data), .thr_live(thr_live), .dom_sel(dom_sel),
    .dom_change(restart), .rd_data(reg_rd_data)
  );

  always_comb begin
    unique case (dom_sel)
      DOM_B:   dom_smp = smp_b;
      DOM_C:   dom_smp = smp_c;
      default: dom_smp = smp_a;
    endcase
  end

  swell_zc #(.SAMPLE_W(SAMPLE_W), .DEBOUNCE(DEBOUNCE)) zc_i (
    .clk(clk), .rst(rst), .restart(restart), .smp_valid(smp_valid),
    .dom_smp(dom_smp), .boundary(boundary)
  );

  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    swell_phase #(.SAMPLE_W(SAMPLE_W), .THR_W(THR_W), .MAX_SAMPLES(MAX_SAMPLES)) ph_i (
      .clk(clk), .rst(rst), .restart(restart), .smp_valid(smp_valid),
      .smp(smp_vec[p]), .boundary(boundary), .thr(thr_act_q[p]),
      .over(over[p]), .nonempty(nonempty[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_act_q      <= '0;
      armed_q        <= 1'b0;
      swell_flags    <= '0;
      decision_valid <= 1'b0;
    end else begin
      decision_valid <= 1'b0;
      if (restart) begin
        armed_q <= 1'b0;
      end else if (boundary) begin
        armed_q   <= 1'b1;
        thr_act_q <= thr_live;
        if (armed_q && nonempty[0]) begin
          swell_flags    <= over;
          decision_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/swell_monitor_chk.sv
module swell_monitor_chk (
  input logic        clk,
  input logic        rst,
  input logic        smp_valid,
  input logic        decision_valid,
  input logic [2:0]  swell_flags,
  input logic        reg_wr_en,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wr_data,
  input logic [1:0]  dom_sel
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (swell_flags == 3'b000 && !decision_valid)); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) decision_valid |=> !decision_valid); // R4
  AST_STROBE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst) decision_valid |-> $past(smp_valid)); // R4
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) !decision_valid |-> $stable(swell_flags)); // R7
  AST_RESTART_NO_DECISION: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == 2'd3 && reg_wr_data[1:0] != dom_sel) |=> !decision_valid); // R9
  AST_DOM_HOLD: assert property (@(posedge clk) disable iff (rst) !reg_wr_en |=> $stable(dom_sel)); // R2
endmodule

bind swell_monitor swell_monitor_chk chk_i (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .decision_valid(decision_valid),
  .swell_flags(swell_flags), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wr_data(reg_wr_data), .dom_sel(dom_sel)
);

// File: tb/swell_monitor_tb_top.sv
module swell_monitor_tb_top;
  localparam int DEB  = 2;
  localparam int MAXN = 1024;
  localparam int PA = 1000000, PB = 2000000, PC = 3000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_a = '0, smp_b = '0, smp_c = '0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic [2:0]  swell_flags;
  logic        decision_valid;

  int checks = 0, failures = 0, n_dec = 0;
  bit done = 0;

  // reference model state, built from the requirements
  bit          m_pol, m_armed;
  int          m_run, m_cnt, m_dom;
  longint      m_sum [3];
  logic [31:0] m_live [3], m_act [3];
  logic [2:0]  m_flags;

  always #2 clk = ~clk;

  swell_monitor dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
    .smp_c(smp_c), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .swell_flags(swell_flags), .decision_valid(decision_valid)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit judge(longint sum, int cnt, logic [31:0] t);
    logic [127:0] l, r;
    l = 128'(sum) << 18;
    r = 128'(t) * 128'(t) * 128'(cnt);
    return (cnt != 0) && (l > r);
  endfunction

  task automatic model_restart();
    m_pol = 0; m_run = 0; m_armed = 0; m_cnt = 0;
    for (int p = 0; p < 3; p++) m_sum[p] = 0;
  endtask

  task automatic send(int a, int b, int c);
    int v [3];
    int d;
    bit exp_valid;
    v[0] = a; v[1] = b; v[2] = c;
    d = (m_dom == 1) ? b : (m_dom == 2) ? c : a;
    exp_valid = 0;
    if ((d < 0) != m_pol && m_run == DEB - 1) begin
      if (m_armed && m_cnt != 0) begin
        exp_valid = 1;
        for (int p = 0; p < 3; p++) m_flags[p] = judge(m_sum[p], m_cnt, m_act[p]);
      end
      m_armed = 1; m_pol = ~m_pol; m_run = 0;
      for (int p = 0; p < 3; p++) begin
        m_act[p] = m_live[p];
        m_sum[p] = longint'(v[p]) * longint'(v[p]);
      end
      m_cnt = 1;
    end else begin
      if ((d < 0) != m_pol) m_run++; else m_run = 0;
      if (m_cnt < MAXN) begin
        for (int p = 0; p < 3; p++) m_sum[p] += longint'(v[p]) * longint'(v[p]);
        m_cnt++;
      end
    end
    smp_valid = 1; smp_a = 24'(a); smp_b = 24'(b); smp_c = 24'(c);
    @(negedge clk);
    smp_valid = 0;
    if (decision_valid) n_dec++;
    chk(decision_valid == exp_valid, "R4", "decision strobe", longint'(decision_valid), longint'(exp_valid));
    chk(swell_flags == m_flags, exp_valid ? "R5" : "R7", "flags", longint'(swell_flags), longint'(m_flags));
  endtask

  task automatic half(int sgn, int n, int pa, int pb, int pc, bit alt);
    for (int i = 0; i < n; i++) begin
      int m;
      m = (alt && (i % 2 == 1)) ? 2 : 1;
      send(sgn * m * pa, sgn * m * pb, sgn * m * pc);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    reg_wr_en = 1; reg_addr = 2'(addr); reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 0;
    if (addr < 3) m_live[addr] = data;
    else if (int'(data[1:0]) != m_dom) begin
      m_dom = int'(data[1:0]);
      model_restart();
    end
  endtask

  task automatic rd(int addr, logic [31:0] exp, string req);
    reg_addr = 2'(addr);
    @(negedge clk);
    chk(reg_rd_data == exp, req, "read data", longint'(reg_rd_data), longint'(exp));
  endtask

  task automatic t_reset();
    chk(swell_flags == 3'b000, "R1", "flags after reset", longint'(swell_flags), 0);
    chk(decision_valid == 1'b0, "R1", "strobe after reset", longint'(decision_valid), 0);
    for (int a = 0; a < 4; a++) rd(a, 32'h0, "R1");
  endtask

  task automatic t_regs();
    wr(0, 32'h1234_5678); wr(1, 32'hCAFE_0001); wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFE);
    rd(0, 32'h1234_5678, "R2"); rd(1, 32'hCAFE_0001, "R2");
    rd(2, 32'hFFFF_FFFF, "R2"); rd(3, 32'h2, "R2");
    wr(3, 32'h0);
    rd(3, 32'h0, "R2");
  endtask

  task automatic t_basic();
    int d0;
    wr(0, PA * 512 - 1); wr(1, PB * 512); wr(2, PC * 512 + 1000);
    d0 = n_dec;
    half(1, 8, PA, PB, PC, 0);
    half(-1, 8, PA, PB, PC, 0);
    chk(n_dec == d0, "R4", "no decision at arming edge", n_dec - d0, 0);
    half(1, 8, PA, PB, PC, 0);
    chk(swell_flags == 3'b001, "R6", "per-phase flags, B equal to threshold", longint'(swell_flags), 1);
    half(-1, 8, PA, PB, PC, 0);
    chk(n_dec == d0 + 2, "R4", "one decision per edge", n_dec - d0, 2);
  endtask

  task automatic t_glitch();
    int d0;
    d0 = n_dec;
    half(1, 3, PA, PB, PC, 0);
    send(-PA, -PB, -PC);
    half(1, 5, PA, PB, PC, 0);
    chk(n_dec == d0 + 1, "R3", "single opposite sample ignored", n_dec - d0, 1);
    half(-1, 8, PA, PB, PC, 0);
    chk(n_dec == d0 + 2, "R3", "confirmed sign change", n_dec - d0, 2);
  endtask

  task automatic t_mixed();
    wr(0, PA * 768); wr(1, PA * 819); wr(2, PA * 800);
    half(1, 8, PA, PA, PA, 1);
    half(-1, 8, PA, PA, PA, 1);
    half(1, 8, PA, PA, PA, 1);
    chk(swell_flags == 3'b101, "R5", "mean square of waveform with harmonic", longint'(swell_flags), 5);
    chk(n_dec > 0, "R10", "window composition via model", n_dec, 1);
  endtask

  task automatic t_thr_update();
    wr(0, PA * 512 - 1); wr(1, PB * 512); wr(2, PC * 512 + 1000);
    half(-1, 8, PA, PB, PC, 0);
    half(1, 4, PA, PB, PC, 0);
    wr(0, 32'hFFFF_FFFF);
    half(1, 4, PA, PB, PC, 0);
    half(-1, 2, PA, PB, PC, 0);
    chk(swell_flags[0] == 1'b1, "R8", "open window keeps old threshold", longint'(swell_flags[0]), 1);
    half(-1, 6, PA, PB, PC, 0);
    half(1, 2, PA, PB, PC, 0);
    chk(swell_flags[0] == 1'b0, "R8", "new threshold at next window", longint'(swell_flags[0]), 0);
  endtask

  task automatic t_dom();
    int d0;
    wr(0, PA * 512 - 1); wr(1, PB * 512 - 1); wr(2, PC * 512 - 1);
    half(-1, 3, PA, PB, PC, 0);
    wr(3, 1);
    d0 = n_dec;
    for (int i = 0; i < 4; i++) send(PA, PB, PC);
    for (int i = 0; i < 4; i++) send(PA, -PB, PC);
    chk(n_dec == d0, "R9", "restart: first edge opens window only", n_dec - d0, 0);
    for (int i = 0; i < 4; i++) send(PA, PB, -PC);
    chk(n_dec == d0 + 1, "R9", "phase B drives edges", n_dec - d0, 1);
    chk(swell_flags == 3'b111, "R9", "flags after B-driven window", longint'(swell_flags), 7);
    wr(3, 3);
    d0 = n_dec;
    half(1, 4, PA, PB, PC, 0);
    half(-1, 4, PA, PB, PC, 0);
    half(1, 4, PA, PB, PC, 0);
    chk(n_dec == d0 + 1, "R9", "select 3 maps to phase A", n_dec - d0, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    m_dom = 0; m_flags = '0;
    for (int p = 0; p < 3; p++) begin m_live[p] = '0; m_act[p] = '0; end
    model_restart();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_glitch();
    t_mixed();
    t_thr_update();
    t_dom();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: run did not end actual=1 expected=0");
    finish_run();
  end
endmodule